// File: doc/BRIEF.md
# AUX Request Framer and Reply Decoder

This block sits between a transaction requester and a DisplayPort AUX channel engine. It accepts one request at a time: three flags (I2C-over-AUX, write, middle-of-transaction), a 20-bit address, a data length of 0 to 16 bytes and up to 16 write bytes. It turns them into the request byte stream and writes that stream into the channel's transmit buffer one byte per cycle. It then presents the transmit byte count and pulses a start strobe.

When the channel raises its done flag, the block sorts the channel's error flags into a single result class using a fixed priority. It also unpacks the reply, which means taking the reply code from the high nibble of the first received byte and copying the returned data bytes into its result register. The result is shown for one cycle as a class, a reply code, a data count and up to 16 data bytes. Before every new transfer, the block first acknowledges the previous done and waits for done to fall, and only then starts loading.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset, req_ready is 1 and res_valid, ch_go, ch_done_ack and tx_we are all 0.
- R2: The 4-bit command is 4'b1000 for a native write and 4'b1001 for a native read. For I2C-over-AUX it is {1'b0, mot, 1'b0, ~write}: write 0, read 1, write with MOT 4, read with MOT 5.
- R3: Transmit byte 0 is {command, addr[19:16]}, byte 1 is addr[15:8] and byte 2 is addr[7:0].
- R4: Byte 3 is (length − 1) when the length is nonzero. When the length is zero, no length byte is sent.
- R5: tx_count is 3 when the length is zero and 4 otherwise, plus the length for any write command. Write bytes follow in order from byte index 4, and only write commands carry them. No index at or above tx_count is ever written.
- R6: Each transfer runs in this order: a one-cycle ch_done_ack pulse, a wait until ch_done is 0, the buffer load, and then exactly one single-cycle ch_go pulse. ch_go is never high while ch_done is high.
- R7: Status bits are 0 hpd-lost, 1 rx-timeout, 2 timeout-state, 3 bad-stop, 4 no-detect, 5 bad-high, 6 bad-low and 7 min-count. Priority is hpd-lost (class 1), then either timeout bit (class 2), then any of bits 3 to 6 (class 3). Bit 7 has no effect.
- R8: When no error flag is set and ch_reply_cnt is 0, the class is 3 (invalid reply) and the count is 0.
- R9: Otherwise the class is 0 (ok), res_reply is bits 7:4 of received byte 0, and res_count is ch_reply_cnt − 1.
- R10: Only for reply code 0 are received bytes 1..n copied to res_data bytes 0..n−1. All other res_data bytes, and all res_data bytes of any non-zero reply code, are 0.
- R11: If the reply code is 0 and ch_reply_cnt − 1 exceeds the requested length, the class is 4 (overflow), with count 0, reply 0 and data 0. A count exactly equal to the length is accepted.
- R12: A request is taken only while req_ready is high. req_ready stays low from acceptance until the result is shown, and req_len must not exceed 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_i2c | input | 1 | I2C-over-AUX request |
| req_write | input | 1 | Write request |
| req_mot | input | 1 | Middle-of-transaction flag (I2C only) |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Data length, 0 to 16 |
| req_wdata | input | 128 | Write bytes, byte k at bits 8k+7:8k |
| tx_we | output | 1 | Transmit buffer write strobe |
| tx_idx | output | 5 | Transmit buffer byte index |
| tx_byte | output | 8 | Transmit buffer byte |
| tx_count | output | 5 | Number of bytes to transmit |
| ch_go | output | 1 | Start strobe to the channel |
| ch_done_ack | output | 1 | Acknowledge of the channel done flag |
| ch_done | input | 1 | Channel finished |
| ch_status | input | 8 | Channel error flags (bit map in R7) |
| ch_reply_cnt | input | 5 | Number of received bytes |
| ch_rx_data | input | 136 | Received bytes, byte 0 is the reply header |
| res_valid | output | 1 | One-cycle result strobe |
| res_class | output | 3 | 0 ok, 1 hpd-lost, 2 timeout, 3 invalid, 4 overflow |
| res_reply | output | 4 | Reply code |
| res_count | output | 5 | Returned data count |
| res_data | output | 128 | Returned data bytes |

## Verification
The embedded properties check, on every cycle, the rules of the start handshake: ch_go only while done is low, and never two cycles in a row. They also check that loads stay below tx_count, that hpd-lost wins over all other flags, that bit 7 alone never spoils an ok result, and that an ok ACK count never exceeds the requested length. The exact header and payload bytes for each command variant, the order of classes when several flags are set at once, the zeroing of data for non-ACK replies, and the boundary between a count equal to the length and one past it can only be shown by the bench. It compares each captured transmit frame and each result with values it computes itself.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_HPD      = 3'd1,
    RES_TIMEOUT  = 3'd2,
    RES_INVALID  = 3'd3,
    RES_OVERFLOW = 3'd4
  } res_class_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_CLR, S_LOAD, S_GO, S_WAIT
  } xact_state_e;

  localparam int ST_HPD      = 0;
  localparam int ST_TMO      = 1;
  localparam int ST_TMO_ST   = 2;
  localparam int ST_BAD_STOP = 3;
  localparam int ST_NO_DET   = 4;
  localparam int ST_BAD_H    = 5;
  localparam int ST_BAD_L    = 6;
  localparam int ST_MIN_CNT  = 7;
  localparam int ST_W        = 8;

  function automatic logic [3:0] cmd_of(input logic i2c, input logic wr, input logic mot);
    if (i2c) return {1'b0, mot, 1'b0, ~wr};
    return {3'b100, ~wr};
  endfunction

endpackage

// File: rtl/aux_hdr_builder.sv
module aux_hdr_builder
  import aux_xact_pkg::*;
#(
  parameter int MAX_DATA = 16,
  localparam int LEN_W  = $clog2(MAX_DATA + 1),
  localparam int CNT_W  = $clog2(MAX_DATA + 5),
  localparam int DATA_W = MAX_DATA * 8
) (
  input  logic              i2c,
  input  logic              wr,
  input  logic              mot,
  input  logic [19:0]       addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  idx,
  output logic [7:0]        byte_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [3:0] cmd;
  logic       has_len;

  assign cmd     = cmd_of(i2c, wr, mot);
  assign has_len = (len != '0);
  assign count_o = (has_len ? CNT_W'(4) : CNT_W'(3)) + (wr ? CNT_W'(len) : CNT_W'(0));

  always_comb begin
    byte_o = 8'h00;
    case (int'(idx))
      0: byte_o = {cmd, addr[19:16]};
      1: byte_o = addr[15:8];
      2: byte_o = addr[7:0];
      3: byte_o = 8'(len - LEN_W'(1));
      default: begin
        for (int k = 0; k < MAX_DATA; k++) begin
          if (int'(idx) == k + 4) byte_o = wdata[k*8 +: 8];
        end
      end
    endcase
  end

endmodule

// File: rtl/aux_status_classifier.sv
module aux_status_classifier
  import aux_xact_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [ST_W-1:0]  status,
  input  logic [CNT_W-1:0] reply_cnt,
  output res_class_e       class_o
);

  logic [ST_W-1:0] flags;
  logic            any_tmo;
  logic            any_bad;

  // the min-count bit is a debug indication and is masked off here
  assign flags   = status & ~(ST_W'(1) << ST_MIN_CNT);
  assign any_tmo = flags[ST_TMO] | flags[ST_TMO_ST];
  assign any_bad = |{flags[ST_BAD_STOP], flags[ST_NO_DET], flags[ST_BAD_H], flags[ST_BAD_L], flags[ST_MIN_CNT]};

  always_comb begin
    if (flags[ST_HPD])           class_o = RES_HPD;
    else if (any_tmo)            class_o = RES_TIMEOUT;
    else if (any_bad)            class_o = RES_INVALID;
    else if (reply_cnt == '0)    class_o = RES_INVALID;
    else                         class_o = RES_OK;
  end

endmodule

// File: rtl/aux_reply_unpack.sv
module aux_reply_unpack #(
  parameter int MAX_DATA = 16,
  localparam int LEN_W  = $clog2(MAX_DATA + 1),
  localparam int CNT_W  = $clog2(MAX_DATA + 5),
  localparam int DATA_W = MAX_DATA * 8,
  localparam int RX_W   = (MAX_DATA + 1) * 8
) (
  input  logic [RX_W-1:0]   rx,
  input  logic [CNT_W-1:0]  reply_cnt,
  input  logic [LEN_W-1:0]  req_len,
  output logic [3:0]        code_o,
  output logic [CNT_W-1:0]  data_cnt_o,
  output logic              ovf_o,
  output logic [DATA_W-1:0] data_o
);

  logic is_ack;

  assign code_o     = 4'(rx[7:0] >> 4);
  assign is_ack     = (code_o == 4'h0);
  assign data_cnt_o = (reply_cnt == '0) ? '0 : reply_cnt - CNT_W'(1);
  assign ovf_o      = is_ack && (data_cnt_o > CNT_W'(req_len));

  for (genvar k = 0; k < MAX_DATA; k++) begin : g_byte
    assign data_o[k*8 +: 8] = (is_ack && !ovf_o && (int'(data_cnt_o) > k)) ? rx[(k+1)*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_xact_pkg::*;
#(
  parameter int MAX_DATA = 16,
  localparam int LEN_W  = $clog2(MAX_DATA + 1),
  localparam int CNT_W  = $clog2(MAX_DATA + 5),
  localparam int DATA_W = MAX_DATA * 8,
  localparam int RX_W   = (MAX_DATA + 1) * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_i2c,
  input  logic              req_write,
  input  logic              req_mot,
  input  logic [19:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              tx_we,
  output logic [CNT_W-1:0]  tx_idx,
  output logic [7:0]        tx_byte,
  output logic [CNT_W-1:0]  tx_count,
  output logic              ch_go,
  output logic              ch_done_ack,
  input  logic              ch_done,
  input  logic [ST_W-1:0]   ch_status,
  input  logic [CNT_W-1:0]  ch_reply_cnt,
  input  logic [RX_W-1:0]   ch_rx_data,
  output logic              res_valid,
  output logic [2:0]        res_class,
  output logic [3:0]        res_reply,
  output logic [CNT_W-1:0]  res_count,
  output logic [DATA_W-1:0] res_data
);

  xact_state_e state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;

  logic              i2c_q, wr_q, mot_q;
  logic [19:0]       addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wdata_q;

  logic req_take, res_take;

  // request framing
  aux_hdr_builder #(.MAX_DATA(MAX_DATA)) u_hdr (
    .i2c(i2c_q), .wr(wr_q), .mot(mot_q), .addr(addr_q), .len(len_q),
    .wdata(wdata_q), .idx(idx_q), .byte_o(tx_byte), .count_o(tx_count)
  );

  // reply classification and unpacking
  res_class_e        cls;
  logic [3:0]        code;
  logic [CNT_W-1:0]  data_cnt;
  logic              ovf;
  logic [DATA_W-1:0] unpacked;

  aux_status_classifier #(.CNT_W(CNT_W)) u_cls (
    .status(ch_status), .reply_cnt(ch_reply_cnt), .class_o(cls)
  );

  aux_reply_unpack #(.MAX_DATA(MAX_DATA)) u_unp (
    .rx(ch_rx_data), .reply_cnt(ch_reply_cnt), .req_len(len_q),
    .code_o(code), .data_cnt_o(data_cnt), .ovf_o(ovf), .data_o(unpacked)
  );

  // sequencing
  assign req_take = (state_q == S_IDLE) && req_valid;
  assign res_take = (state_q == S_WAIT) && ch_done;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      S_IDLE: if (req_valid) state_d = S_ACK;
      S_ACK:  state_d = S_CLR;
      S_CLR:  if (!ch_done) begin
                state_d = S_LOAD;
                idx_d   = '0;
              end
      S_LOAD: if (idx_q == tx_count - CNT_W'(1)) state_d = S_GO;
              else idx_d = idx_q + CNT_W'(1);
      S_GO:   state_d = S_WAIT;
      S_WAIT: if (ch_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i2c_q   <= 1'b0;
      wr_q    <= 1'b0;
      mot_q   <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else if (req_take) begin
      i2c_q   <= req_i2c;
      wr_q    <= req_write;
      mot_q   <= req_mot;
      addr_q  <= req_addr;
      len_q   <= req_len;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready   = (state_q == S_IDLE);
  assign ch_done_ack = (state_q == S_ACK);
  assign tx_we       = (state_q == S_LOAD);
  assign tx_idx      = idx_q;
  assign ch_go       = (state_q == S_GO);

  // result
  res_class_e        res_cls_d;
  logic [3:0]        res_reply_d;
  logic [CNT_W-1:0]  res_count_d;
  logic [DATA_W-1:0] res_data_d;

  always_comb begin
    res_cls_d   = cls;
    res_reply_d = 4'h0;
    res_count_d = '0;
    res_data_d  = '0;
    if (cls == RES_OK) begin
      if (ovf) begin
        res_cls_d = RES_OVERFLOW;
      end else begin
        res_reply_d = code;
        res_count_d = data_cnt;
        res_data_d  = unpacked;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_class <= RES_OK;
      res_reply <= 4'h0;
      res_count <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= res_take;
      if (res_take) begin
        res_class <= res_cls_d;
        res_reply <= res_reply_d;
        res_count <= res_count_d;
        res_data  <= res_data_d;
      end
    end
  end

  // properties
  a_r6_go_only_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ch_go |-> !ch_done);
  a_r6_go_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ch_go |=> !ch_go);
  a_r5_load_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |-> (tx_idx < tx_count));
  a_r7_hpd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (res_take && ch_status[ST_HPD]) |=> (res_valid && res_class == RES_HPD));
  a_r7_mincnt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (res_take && ch_status[ST_W-2:0] == '0 && ch_reply_cnt != '0 && ch_rx_data[7:4] != 4'h0)
      |=> (res_class == RES_OK));
  a_r11_ack_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class == RES_OK && res_reply == 4'h0) |-> (res_count <= CNT_W'(len_q)));
  a_r12_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (int'(req_len) <= MAX_DATA));
  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/aux_xact_engine_bench.sv
`timescale 1ns/1ps
module aux_xact_engine_bench;

  localparam int MD   = 16;
  localparam int CW   = 5;
  localparam int LW   = 5;
  localparam int DW   = MD * 8;
  localparam int RW   = (MD + 1) * 8;
  localparam int FW   = (MD + 4) * 8;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic          req_valid, req_ready, req_i2c, req_write, req_mot;
  logic [19:0]   req_addr;
  logic [LW-1:0] req_len;
  logic [DW-1:0] req_wdata;
  logic          tx_we, ch_go, ch_done_ack, ch_done;
  logic [CW-1:0] tx_idx, tx_count, ch_reply_cnt, res_count;
  logic [7:0]    tx_byte, ch_status;
  logic [RW-1:0] ch_rx_data;
  logic          res_valid;
  logic [2:0]    res_class;
  logic [3:0]    res_reply;
  logic [DW-1:0] res_data;

  aux_xact_engine u_aux_xact_engine (.*);

  int checks = 0;
  int errors = 0;
  int results_seen = 0;

  typedef struct { string tag; int cnt; logic [FW-1:0] bytes; } frame_t;
  typedef struct { string tag; int cls; int code; int cnt; logic [DW-1:0] data; } res_t;
  frame_t frame_q[$];
  res_t   res_q[$];

  logic [7:0]    nxt_status;
  logic [CW-1:0] nxt_cnt;
  logic [RW-1:0] nxt_rx;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic frame_t ref_frame(input string tag, input bit i2c, input bit wr, input bit mot,
                                       input logic [19:0] addr, input int len, input logic [DW-1:0] wd);
    frame_t f;
    logic [3:0] cmd;
    int n;
    cmd = i2c ? {1'b0, mot, 1'b0, ~wr} : {3'b100, ~wr};
    f.tag = tag;
    f.bytes = '0;
    f.bytes[7:0]   = {cmd, addr[19:16]};
    f.bytes[15:8]  = addr[15:8];
    f.bytes[23:16] = addr[7:0];
    n = 3;
    if (len != 0) begin
      f.bytes[31:24] = 8'(len - 1);
      n = 4;
    end
    if (wr) begin
      for (int k = 0; k < len; k++) f.bytes[(n+k)*8 +: 8] = wd[k*8 +: 8];
      n += len;
    end
    f.cnt = n;
    return f;
  endfunction

  // channel model
  logic [FW-1:0] cap;
  bit acked = 1'b1;
  int pend = 0;
  initial begin
    ch_done = 1'b0; ch_status = '0; ch_reply_cnt = '0; ch_rx_data = '0; cap = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (ch_done_ack) begin
          ch_done = 1'b0;
          acked = 1'b1;
          cap = '0;
        end
        if (tx_we) cap[tx_idx*8 +: 8] = tx_byte;
        if (ch_go) begin
          frame_t f;
          f = frame_q.pop_front();
          chk(int'(tx_count) == f.cnt, "R5", "tx_count", FW'(tx_count), FW'(f.cnt));
          chk(cap == f.bytes, f.tag, "frame", cap, f.bytes);
          chk(!ch_done && acked, "R6", "go while done/unacked", FW'(ch_done), 0);
          chk(!req_ready, "R12", "ready while busy", FW'(req_ready), 0);
          pend = 3;
        end else if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            ch_status = nxt_status;
            ch_reply_cnt = nxt_cnt;
            ch_rx_data = nxt_rx;
            ch_done = 1'b1;
            acked = 1'b0;
          end
        end
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        res_t e;
        e = res_q.pop_front();
        chk(int'(res_class) == e.cls, e.tag, "class", FW'(res_class), FW'(e.cls));
        chk(int'(res_reply) == e.code, e.tag, "reply", FW'(res_reply), FW'(e.code));
        chk(int'(res_count) == e.cnt, e.tag, "count", FW'(res_count), FW'(e.cnt));
        chk(res_data == e.data, e.tag, "data", FW'(res_data), FW'(e.data));
        results_seen++;
      end
    end
  end

  task automatic xact(input string tag, input bit i2c, input bit wr, input bit mot,
                      input logic [19:0] addr, input int len, input logic [DW-1:0] wd,
                      input logic [7:0] st, input int rcnt, input logic [RW-1:0] rx,
                      input int ecls, input int ecode, input int ecnt, input logic [DW-1:0] edata);
    res_t r;
    int seen;
    frame_q.push_back(ref_frame(tag, i2c, wr, mot, addr, len, wd));
    r.tag = tag; r.cls = ecls; r.code = ecode; r.cnt = ecnt; r.data = edata;
    res_q.push_back(r);
    nxt_status = st; nxt_cnt = CW'(rcnt); nxt_rx = rx;
    seen = results_seen;
    @(negedge clk);
    req_i2c = i2c; req_write = wr; req_mot = mot; req_addr = addr;
    req_len = LW'(len); req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait (results_seen > seen);
  endtask

  // watchdog
  initial begin
    #(100000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [RW-1:0] rx;
    logic [DW-1:0] ed;
    req_valid = 0; req_i2c = 0; req_write = 0; req_mot = 0;
    req_addr = '0; req_len = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !res_valid && !ch_go && !ch_done_ack && !tx_we, "R1", "reset outputs",
        FW'({req_ready, res_valid, ch_go, ch_done_ack, tx_we}), FW'(5'b10000));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R9 R10: native read, 4 bytes ACK
    rx = '0; rx[39:0] = 40'hDDCCBBAA00;
    xact("R3", 0, 0, 0, 20'h12345, 4, '0, 8'h00, 5, rx, 0, 0, 4, DW'(32'hDDCCBBAA));
    // R5: native write two bytes
    rx = '0;
    xact("R5", 0, 1, 0, 20'hABCDE, 2, DW'(16'h2211), 8'h00, 1, rx, 0, 0, 0, '0);
    // R4: I2C read with MOT, zero length
    xact("R4", 1, 0, 1, 20'h00050, 0, '0, 8'h00, 1, rx, 0, 0, 0, '0);
    // R2: I2C write with MOT one byte
    xact("R2", 1, 1, 1, 20'h00050, 1, DW'(8'h7E), 8'h00, 1, rx, 0, 0, 0, '0);
    // R5: I2C write zero length carries no payload
    xact("R5", 1, 1, 0, 20'hF0001, 0, DW'(8'hEE), 8'h00, 1, rx, 0, 0, 0, '0);
    // R10: NACK with bytes, data not copied
    rx = '0; rx[23:0] = 24'h998810;
    xact("R10", 1, 0, 0, 20'h00050, 2, '0, 8'h00, 3, rx, 0, 1, 2, '0);
    // R9: DEFER code
    rx = '0; rx[7:0] = 8'h20;
    xact("R9", 0, 0, 0, 20'h00100, 1, '0, 8'h00, 1, rx, 0, 2, 0, '0);
    // R7: hpd beats timeout and bad-stop
    rx = '0; rx[15:0] = 16'h5500;
    xact("R7", 0, 0, 0, 20'h00200, 1, '0, 8'b0000_1011, 2, rx, 1, 0, 0, '0);
    // R7: timeout-state beats bad-low
    xact("R7", 0, 0, 0, 20'h00200, 1, '0, 8'b0100_0100, 2, rx, 2, 0, 0, '0);
    // R7: bad-high alone is invalid
    xact("R7", 0, 0, 0, 20'h00200, 1, '0, 8'b0010_0000, 2, rx, 3, 0, 0, '0);
    // R7: min-count bit ignored
    rx = '0; rx[15:0] = 16'h5A00;
    xact("R7", 0, 0, 0, 20'h00300, 1, '0, 8'b1000_0000, 2, rx, 0, 0, 1, DW'(8'h5A));
    // R8: empty reply
    xact("R8", 0, 0, 0, 20'h00300, 1, '0, 8'h00, 0, rx, 3, 0, 0, '0);
    // R11: ACK with more data than requested
    rx = '0; rx[39:0] = 40'h4433221100;
    xact("R11", 0, 0, 0, 20'h00400, 2, '0, 8'h00, 5, rx, 4, 0, 0, '0);
    // R11: full 16-byte read, count equal to length accepted
    rx = '0; ed = '0;
    for (int k = 0; k < MD; k++) begin
      rx[(k+1)*8 +: 8] = 8'(8'hA0 + k);
      ed[k*8 +: 8] = 8'(8'hA0 + k);
    end
    xact("R11", 1, 0, 0, 20'h00050, 16, '0, 8'h00, 17, rx, 0, 0, 16, ed);
    // R5 R6: full 16-byte native write, longest frame
    rx = '0;
    xact("R6", 0, 1, 0, 20'h80000, 16, {8{16'hC3A5}}, 8'h00, 1, rx, 0, 0, 0, '0);

    repeat (4) @(negedge clk);
    chk(frame_q.size() == 0 && res_q.size() == 0, "R12", "pending items",
        FW'(frame_q.size() + res_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule